// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

This block turns 18-bit stereo sample pairs into a one-wire serial audio stream. It is a slave: the bit clock and the word-select (frame) clock come from outside. It watches both of them in its own system clock domain. A static format input selects between two layouts. The left-justified layout places the MSB in the first bit slot after a word-select change, and a high word select marks the left channel. The I2S layout leaves the first slot empty and places the MSB in the second slot, and a low word select marks the left channel.

A new left/right pair is taken through a valid/ready handshake once per frame, at the start of the left half. If no pair is offered at that moment, the last pair is sent again and an underrun pulse is raised. Every half-frame has 32 bit slots. The slots that do not carry sample bits are driven to zero. The data line only changes in the system-clock cycle that follows a detected falling edge of the bit clock, so it is steady at every rising edge.

The controller has three states. `ST_IDLE` is left on the first bit-clock fall, and that fall records a reference word select. `ST_ARM` waits for a word select that differs from the reference at a fall. `ST_RUN` restarts the slot count at every such change and otherwise advances the count on each fall, saturating at the last slot.

Top module: `dual_fmt_ser_tx`

## Requirements
- R1: After reset, `sdata`, `smp_ready` and `underrun` stay 0 until the first word-select change has been seen at a bit-clock fall.
- R2: With `fmt_i2s`=0, sample bits 17 down to 0 occupy slots 0 to 17 of a half-frame. Slot 0 is the first bit period after the word-select change.
- R3: With `fmt_i2s`=1, slot 0 carries 0 and sample bits 17 down to 0 occupy slots 1 to 18.
- R4: With `fmt_i2s`=0, `wsel`=1 carries the left sample. With `fmt_i2s`=1, `wsel`=0 carries the left sample.
- R5: Slots of a half-frame that carry no sample bit drive `sdata`=0.
- R6: `sdata` changes only in the system-clock cycle after a bit-clock fall has been detected, so it is stable at each bit-clock rising edge.
- R7: `smp_ready` pulses for one system-clock cycle, exactly once per frame, when the left half begins. A pair offered with `smp_valid` in that cycle is sent in that frame.
- R8: If `smp_valid` is 0 while `smp_ready` is high, `underrun` pulses in the same cycle and the previous pair is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock from the external master |
| wsel | input | 1 | Word-select (frame) clock from the external master |
| fmt_i2s | input | 1 | 0: left-justified layout, 1: I2S layout (static) |
| smp_valid | input | 1 | A stereo pair is offered |
| smp_left | input | 18 | Left sample, two's complement |
| smp_right | input | 18 | Right sample, two's complement |
| smp_ready | output | 1 | One-cycle pulse: pair taken if `smp_valid` is high |
| underrun | output | 1 | One-cycle pulse: no pair offered, previous pair repeated |
| sdata | output | 1 | Serial data output |

## Verification
A slot counter that is off by one shifts the whole sample word by a bit position. The error shows up in the very next half-frame as a captured word that differs from the expected word, so the bench compares all 32 slots of both halves against the format rule. A controller stuck in the wrong state shows differently: either the data line stays silent through a whole frame, or `smp_ready` is missing in that frame. A wrong channel polarity swaps the two halves within the first frame. A broken underrun path produces a repeated frame whose words or pulse count do not match.

// File: rtl/dual_fmt_ser_tx_pkg.sv
package dual_fmt_ser_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } txs_state_e;

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } txs_fmt_e;
endpackage

// File: rtl/dual_fmt_ser_tx_edge.sv
module dual_fmt_ser_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic wsel,
    output logic bclk_fall,
    output logic ws_now
);
    logic bclk_q, bclk_qq, ws_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q  <= 1'b1;
            bclk_qq <= 1'b1;
            ws_q    <= 1'b0;
        end else begin
            bclk_q  <= bclk;
            bclk_qq <= bclk_q;
            ws_q    <= wsel;
        end
    end

    assign bclk_fall = bclk_qq & ~bclk_q;
    assign ws_now    = ws_q;
endmodule

// File: rtl/dual_fmt_ser_tx_ctrl.sv
module dual_fmt_ser_tx_ctrl
    import dual_fmt_ser_tx_pkg::*;
#(
    parameter int SLOTS  = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ws_now,
    input  txs_fmt_e          fmt,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              left_nxt,
    output logic              run_nxt,
    output logic              running,
    output logic              frame_edge,
    output logic              load_now
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    txs_state_e        state, state_nxt;
    logic [SLOT_W-1:0] slot;
    logic              ws_ref;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            slot   <= '0;
            ws_ref <= 1'b0;
        end else begin
            state <= state_nxt;
            slot  <= slot_nxt;
            if (tick) ws_ref <= ws_now;
        end
    end

    assign frame_edge = tick && (state != ST_IDLE) && (ws_now != ws_ref);

    always_comb begin
        state_nxt = state;
        slot_nxt  = slot;
        unique case (state)
            ST_IDLE: if (tick) state_nxt = ST_ARM;
            ST_ARM: begin
                if (frame_edge) begin
                    state_nxt = ST_RUN;
                    slot_nxt  = '0;
                end
            end
            ST_RUN: begin
                if (frame_edge)
                    slot_nxt = '0;
                else if (tick && slot != SLOT_LAST)
                    slot_nxt = slot + SLOT_W'(1);
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // output process
    always_comb begin
        run_nxt  = (state_nxt == ST_RUN);
        running  = (state == ST_RUN);
        left_nxt = (fmt == FMT_I2S) ? ~ws_now : ws_now;
        load_now = frame_edge && left_nxt;
    end
endmodule

// File: rtl/dual_fmt_ser_tx_hold.sv
module dual_fmt_ser_tx_hold #(
    parameter int SAMPLE_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                ready,
    output logic                underrun,
    output logic [SAMPLE_W-1:0] cur_left,
    output logic [SAMPLE_W-1:0] cur_right
);
    logic [SAMPLE_W-1:0] held_l, held_r;
    logic                take;

    assign take     = load & in_valid;
    assign ready    = load;
    assign underrun = load & ~in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_l <= '0;
            held_r <= '0;
        end else if (take) begin
            held_l <= in_left;
            held_r <= in_right;
        end
    end

    assign cur_left  = take ? in_left  : held_l;
    assign cur_right = take ? in_right : held_r;
endmodule

// File: rtl/dual_fmt_ser_tx.sv
module dual_fmt_ser_tx
    import dual_fmt_ser_tx_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int SLOTS    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                wsel,
    input  logic                fmt_i2s,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                smp_ready,
    output logic                underrun,
    output logic                sdata
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int POS_W  = SLOT_W + 1;
    localparam int IDX_W  = $clog2(SAMPLE_W);

    logic                bclk_fall, ws_now;
    logic [SLOT_W-1:0]   slot_nxt;
    logic                left_nxt, run_nxt, running, frame_edge, load_now;
    logic [SAMPLE_W-1:0] cur_l, cur_r, word;
    logic [POS_W-1:0]    pos;
    logic [IDX_W-1:0]    idx;
    logic                in_win, bit_nxt, sdata_q;

    dual_fmt_ser_tx_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .wsel      (wsel),
        .bclk_fall (bclk_fall),
        .ws_now    (ws_now)
    );

    dual_fmt_ser_tx_ctrl #(.SLOTS(SLOTS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bclk_fall),
        .ws_now     (ws_now),
        .fmt        (txs_fmt_e'(fmt_i2s)),
        .slot_nxt   (slot_nxt),
        .left_nxt   (left_nxt),
        .run_nxt    (run_nxt),
        .running    (running),
        .frame_edge (frame_edge),
        .load_now   (load_now)
    );

    dual_fmt_ser_tx_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_now),
        .in_valid  (smp_valid),
        .in_left   (smp_left),
        .in_right  (smp_right),
        .ready     (smp_ready),
        .underrun  (underrun),
        .cur_left  (cur_l),
        .cur_right (cur_r)
    );

    // slot position relative to the MSB; I2S delays it by one slot
    always_comb begin
        word    = left_nxt ? cur_l : cur_r;
        pos     = {1'b0, slot_nxt} - POS_W'(fmt_i2s);
        in_win  = (slot_nxt >= SLOT_W'(fmt_i2s)) && (pos < POS_W'(SAMPLE_W));
        idx     = in_win ? (IDX_W'(SAMPLE_W - 1) - IDX_W'(pos)) : '0;
        bit_nxt = in_win & word[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sdata_q <= 1'b0;
        else if (bclk_fall)
            sdata_q <= run_nxt & bit_nxt;
    end

    assign sdata = sdata_q;
endmodule

// File: rtl/dual_fmt_ser_tx_chk.sv
module dual_fmt_ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic sdata,
    input logic bclk_fall,
    input logic running,
    input logic frame_edge,
    input logic smp_ready,
    input logic smp_valid,
    input logic underrun
);
    a_r1_silent_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !sdata);

    a_r6_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bclk_fall) |-> $stable(sdata));

    a_r7_ready_at_frame_edge: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> frame_edge);

    a_r7_ready_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    a_r8_underrun_only_unoffered: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (smp_ready && !smp_valid));
endmodule

bind dual_fmt_ser_tx dual_fmt_ser_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdata      (sdata),
    .bclk_fall  (bclk_fall),
    .running    (running),
    .frame_edge (frame_edge),
    .smp_ready  (smp_ready),
    .smp_valid  (smp_valid),
    .underrun   (underrun)
);

// File: tb/sim_dual_fmt_ser_tx.sv
module sim_dual_fmt_ser_tx;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 18;
    localparam int SLOTS = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b1;
    logic         wsel = 1'b0;
    logic         fmt = 1'b0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_l = '0, smp_r = '0;
    logic         smp_ready, underrun, sdata;

    int n_chk = 0, n_bad = 0;
    int rdy_seen, udr_seen, stab_bad;
    bit drop_pending = 0;
    bit done = 0;
    logic [W-1:0] last_l, last_r;

    dual_fmt_ser_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .wsel      (wsel),
        .fmt_i2s   (fmt),
        .smp_valid (smp_valid),
        .smp_left  (smp_l),
        .smp_right (smp_r),
        .smp_ready (smp_ready),
        .underrun  (underrun),
        .sdata     (sdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clk_step();
        @(negedge clk);
        if (drop_pending) begin
            smp_valid = 1'b0;
            drop_pending = 0;
        end
        if (smp_ready) begin
            rdy_seen++;
            drop_pending = 1;
        end
        if (underrun) udr_seen++;
    endtask

    task automatic slot_cycle(input logic ws, output logic b);
        logic b2;
        bclk = 1'b0;
        wsel = ws;
        repeat (4) clk_step();
        b = sdata;
        bclk = 1'b1;
        repeat (4) clk_step();
        b2 = sdata;
        if (b2 !== b) stab_bad++;
    endtask

    task automatic run_half(input logic ws, output logic [31:0] cap);
        logic b;
        cap = '0;
        for (int s = 0; s < SLOTS; s++) begin
            slot_cycle(ws, b);
            cap[31-s] = b;
        end
    endtask

    function automatic logic [31:0] exp_half(input logic [W-1:0] w, input logic i2s);
        logic [31:0] e = '0;
        for (int k = 0; k < SLOTS; k++) begin
            int p = k - (i2s ? 1 : 0);
            if (p >= 0 && p < W) e[31-k] = w[W-1-p];
        end
        return e;
    endfunction

    // R1: reset state and silence during the lead-in half before any frame edge
    task automatic t_reset(input logic fmt_val);
        logic [31:0] cap;
        rst_n = 1'b0;
        fmt = fmt_val;
        smp_valid = 1'b0;
        bclk = 1'b1;
        wsel = fmt_val ? 1'b1 : 1'b0;
        last_l = '0;
        last_r = '0;
        repeat (3) @(negedge clk);
        check(sdata === 1'b0 && smp_ready === 1'b0 && underrun === 1'b0, "R1",
              "outputs in reset", {29'd0, sdata, smp_ready, underrun}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rdy_seen = 0; udr_seen = 0; stab_bad = 0;
        run_half(fmt_val ? 1'b1 : 1'b0, cap);
        check(cap === 32'd0, "R1", "sdata before first edge", cap, 32'd0);
        check(rdy_seen == 0 && udr_seen == 0, "R1", "handshake before first edge",
              rdy_seen + udr_seen, 0);
    endtask

    // R2/R3, R4, R5, R6, R7, R8: one full frame
    task automatic t_frame(input logic [W-1:0] l, input logic [W-1:0] r, input bit give);
        logic [31:0] capl, capr;
        logic left_ws = fmt ? 1'b0 : 1'b1;
        string fr = fmt ? "R3" : "R2";
        if (give) begin
            smp_l = l; smp_r = r; smp_valid = 1'b1;
        end else begin
            smp_valid = 1'b0;
        end
        rdy_seen = 0; udr_seen = 0; stab_bad = 0;
        run_half(left_ws, capl);
        run_half(~left_ws, capr);
        if (give) begin
            last_l = l; last_r = r;
        end
        check(capl === exp_half(last_l, fmt), {fr, " R4 R5"}, "left half",
              capl, exp_half(last_l, fmt));
        check(capr === exp_half(last_r, fmt), {fr, " R4 R5"}, "right half",
              capr, exp_half(last_r, fmt));
        check(rdy_seen == 1, "R7", "ready pulses per frame", rdy_seen, 1);
        check(udr_seen == (give ? 0 : 1), "R8", "underrun pulses per frame",
              udr_seen, give ? 1'b0 : 1'b1);
        check(stab_bad == 0, "R6", "sdata moved while bclk high", stab_bad, 0);
    endtask

    task automatic t_format(input logic fmt_val);
        t_reset(fmt_val);
        t_frame(18'h2A5C3, 18'h15A3C, 1);
        t_frame(18'h3FFFF, 18'h00001, 1);
        t_frame(18'h00000, 18'h00000, 0);   // R8: repeat previous pair
        t_frame(18'h20000, 18'h1FFFE, 1);
    endtask

    initial begin
        @(negedge clk);
        t_format(1'b0);
        t_format(1'b1);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7 actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule